// File: doc/BRIEF.md
# Counter-Addressed Memory Delay Line

This block delays a small bundle of logic signals by a large, fixed number of sample periods. A single-port memory holds the samples, and a free-running binary counter supplies its address. Each sample period lasts two system clocks. In the first clock the block reads the cell at the current address. In the second clock it overwrites that cell with the new input sample, and the address then advances by one. A sample written into a cell is read back when the counter returns to that cell after one full wrap. The delay is therefore the number of cells times the sample period.

Each memory word is one bit per lane, so several unrelated signals are delayed side by side. A hold register drives the outputs. It is loaded only in the read clock and keeps its value through the write clock. Until the first wrap after reset completes, the memory holds no written data. In that time the outputs are forced low and a valid flag stays low.

Integrators align their input changes to sample boundaries using the `wr_phase` output. The input is captured at the clock edge that ends a clock in which `wr_phase` is high. An input that changes at some other point is seen late by up to one sample period.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_n` is low, `dout` is all zero, `dout_valid` is 0 and `wr_phase` is 0. The first clock after reset is a read clock.
- R2: `wr_phase` alternates on every clock after reset: 0 (read), then 1 (write), then 0, and so on. This gives one sample per two clocks.
- R3: The input `din` is captured only at the rising edge that ends a clock with `wr_phase`=1. Values present on `din` while `wr_phase`=0 have no effect on any output.
- R4: Sample k (counting from 0 after reset) appears on `dout` exactly 2^ADDR_W sample periods later. It is loaded at the read edge of period k+2^ADDR_W.
- R5: Each of the LANES bits of `din` is delayed independently, with bit i of `din` reappearing on bit i of `dout`.
- R6: `dout` and `dout_valid` change only at the edge that ends a read clock. They are held unchanged across the write clock.
- R7: `dout_valid` rises at the read edge of period 2^ADDR_W and then stays high. While it is low, `dout` is zero.
- R8: Asserting `rst_n` low mid-stream restarts the address at 0, drops `dout_valid` and zeroes `dout`. The valid flag then returns only after a fresh full wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | LANES | Input samples, one bit per lane |
| wr_phase | output | 1 | High during the write clock of each sample period |
| dout | output | LANES | Delayed samples, held over the write clock |
| dout_valid | output | 1 | High once the first full address wrap has completed |

## Verification
A counter that skips or stalls shows up at the ports as a delay longer or shorter than 2^ADDR_W periods. With varied per-lane data, this shows as a mismatch on the first valid sample. A phase toggle that slips breaks the alternation of `wr_phase` within one clock. If the read and write order is swapped inside a period, the output echoes the input of the same period instead of the delayed one, which is visible as soon as `dout_valid` rises. A broken hold or a broken zero-gating shows in the write clock or in the pre-wrap window. Junk driven on `din` during read clocks exposes any capture outside the write edge.

// File: rtl/ram_delay_line_pkg.sv
// Package: shared types for the counter-addressed delay line.
// Assumes: nothing beyond IEEE 1800-2017.
package ram_delay_line_pkg;

    // Two clocks form one sample period: read the cell first, then write it.
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

endpackage

// File: rtl/rdl_phase_gen.sv
// Module: rdl_phase_gen
// Splits the system clock into alternating read and write clocks.
// Assumes: the first clock after reset is a read clock.
module rdl_phase_gen
    import ram_delay_line_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);

    phase_e phase_q;

    // Toggle the phase every clock; reset lands on the read clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_READ;
        end else if (phase_q == PH_READ) begin
            phase_q <= PH_WRITE;
        end else begin
            phase_q <= PH_READ;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/rdl_addr_ctr.sv
// Module: rdl_addr_ctr
// Free-running binary address counter with a sticky wrap flag.
// Assumes: adv is high for exactly one clock per sample period (the write clock).
module rdl_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              wrapped
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;
    logic              wrapped_q;

    // Advance the address after each write; it rolls over naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (adv) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Remember that every cell has been written at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrapped_q <= 1'b0;
        end else if (adv && (addr_q == LAST_ADDR)) begin
            wrapped_q <= 1'b1;
        end
    end

    assign addr    = addr_q;
    assign wrapped = wrapped_q;

endmodule

// File: rtl/rdl_lane.sv
// Module: rdl_lane
// One bit lane: a 2^ADDR_W x 1 storage column and its output hold flop.
// Assumes: rd_en and wr_en are never high together; armed gates stale contents.
module rdl_lane #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              armed,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din_bit,
    output logic              hold_bit
);

    localparam int DEPTH = 1 << ADDR_W;

    logic             cells [DEPTH];
    logic             hold_q;

    // Store the lane's sample into the current cell during the write clock.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= din_bit;
        end
    end

    // Capture the old cell content in the read clock, zero before the first wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (rd_en) begin
            hold_q <= armed ? cells[addr] : 1'b0;
        end
    end

    assign hold_bit = hold_q;

endmodule

// File: rtl/ram_delay_line.sv
// Module: ram_delay_line (top)
// Delays LANES signals by 2^ADDR_W sample periods through a counter-addressed
// memory, reading each cell before overwriting it within the same period.
// Assumes: din is meant to change at sample boundaries (see wr_phase).
module ram_delay_line
    import ram_delay_line_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic             wr_phase,
    output logic [LANES-1:0] dout,
    output logic             dout_valid
);

    phase_e            phase;
    logic              rd_en;
    logic              wr_en;
    logic [ADDR_W-1:0] addr_q;
    logic              wrapped;
    logic              valid_q;
    logic [LANES-1:0]  hold;

    rdl_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    assign rd_en = (phase == PH_READ);
    assign wr_en = (phase == PH_WRITE);

    rdl_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (wr_en),
        .addr    (addr_q),
        .wrapped (wrapped)
    );

    // One storage column per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rdl_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (rd_en),
            .wr_en    (wr_en),
            .armed    (wrapped),
            .addr     (addr_q),
            .din_bit  (din[g]),
            .hold_bit (hold[g])
        );
    end

    // Valid flag moves with the held data, at the read edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (rd_en) begin
            valid_q <= wrapped;
        end
    end

    assign wr_phase   = wr_en;
    assign dout       = hold;
    assign dout_valid = valid_q;

endmodule

// File: rtl/ram_delay_line_chk.sv
// Module: ram_delay_line_chk
// Property checker for ram_delay_line, attached with bind below.
// Assumes: synchronous active-low reset.
module ram_delay_line_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_phase,
    input logic [LANES-1:0]  dout,
    input logic              dout_valid,
    input logic [ADDR_W-1:0] addr
);

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_phase |=> wr_phase); // R2
    AST_READ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> !wr_phase); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> addr == ADDR_W'($past(addr) + 1'b1)); // R4
    AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_phase |=> $stable(addr)); // R4
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> $stable(dout) && $stable(dout_valid)); // R6
    AST_ZERO_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> dout == '0); // R7
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> dout_valid); // R7

endmodule

bind ram_delay_line ram_delay_line_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_phase   (wr_phase),
    .dout       (dout),
    .dout_valid (dout_valid),
    .addr       (addr_q)
);

// File: tb/ram_delay_line_tb.sv
// Scoreboard bench: driver pushes each written sample, monitor pops at the
// read edge 2^ADDR_W periods later and compares.
module ram_delay_line_tb;

    localparam int LANES  = 4;
    localparam int ADDR_W = 5;
    localparam int N      = 1 << ADDR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] din = '0;
    logic             wr_phase;
    logic [LANES-1:0] dout;
    logic             dout_valid;

    int               errs = 0;
    int               checks = 0;
    int               per = 0;
    bit               done = 1'b0;
    logic [LANES-1:0] q[$];
    logic [LANES-1:0] last_dout = '0;
    logic             last_valid = 1'b0;
    logic             prev_ph = 1'b0;

    always #4 clk = ~clk;

    ram_delay_line #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .wr_phase   (wr_phase),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h (period %0d)", req, act, exp, per);
        end
    endtask

    // Driver: junk during read clocks (R3), the real sample for the write clock.
    task automatic drive_period(input logic [LANES-1:0] s);
        @(negedge clk);
        while (!wr_phase) begin
            din = ~s ^ LANES'($urandom);
            @(negedge clk);
        end
        din = s;
        q.push_back(s);
    endtask

    // Monitor: compare just after read edges, check the hold after write edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_phase) begin
                check(prev_ph == 1'b0, "R2", prev_ph, 0);
                if (per >= N) begin
                    logic [LANES-1:0] e;
                    e = (q.size() > 0) ? q.pop_front() : 'x;
                    check(dout === e, "R4/R5/R3", dout, e);
                    check(dout_valid === 1'b1, "R7", dout_valid, 1);
                end else begin
                    check(dout === '0 && dout_valid === 1'b0, "R7", {dout, dout_valid}, 0);
                end
                last_dout  = dout;
                last_valid = dout_valid;
                per++;
            end else if (per > 0) begin
                check(prev_ph == 1'b1, "R2", prev_ph, 1);
                check(dout === last_dout && dout_valid === last_valid, "R6",
                      {dout, dout_valid}, {last_dout, last_valid});
            end
        end
        prev_ph = wr_phase;
    end

    task automatic apply_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dout === '0 && dout_valid === 1'b0 && wr_phase === 1'b0, req,
              {dout, dout_valid, wr_phase}, 0);
        q.delete();
        per = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        apply_reset("R1");
        // Patterns: walking lane bits, all ones, zeros, alternation, random (R5)
        for (int i = 0; i < N; i++) drive_period(LANES'(1 << (i % LANES)));
        for (int i = 0; i < 8; i++) drive_period('1);
        for (int i = 0; i < 8; i++) drive_period('0);
        for (int i = 0; i < 16; i++) drive_period((i % 2) ? 4'b1010 : 4'b0101);
        for (int i = 0; i < 3 * N; i++) drive_period(LANES'($urandom));
        // R8: mid-stream reset restarts the wrap
        apply_reset("R8");
        for (int i = 0; i < 2 * N + 4; i++) drive_period(LANES'($urandom));
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule